// File: doc/BRIEF.md
# Slot-Port Network Interrupt Aggregator

This block gathers network interrupt requests coming from seven adapter slots, each slot having up to eight ports, and folds them into one interrupt line toward the CPU. A request is a one-cycle set or clear pulse that carries a slot number and a port number. Every slot owns an 8-bit lane inside one of two 32-bit status banks. The slots are spread across the banks in an interleaved, non-linear pattern.

Each status bank has a 32-bit mask register beside it. The CPU reaches all four registers over a small register bus with an address, read and write strobes, and 32-bit data. The status banks can only be read. The masks can be read and written. The interrupt line is registered, and it is high whenever some status bit is set under a set mask bit.

Top module: `netirq_agg`

## Requirements
- R1: Slot lanes: bank 0 holds slot 0 at bit 0, slot 1 at bit 8, slot 4 at bit 16 and slot 3 at bit 24. Bank 1 holds slot 2 at bit 8, slot 6 at bit 16 and slot 5 at bit 24. Bank 1 bits 7:0 are never set.
- R2: A set pulse (`set_vld`) for slot s and port p (0..7) sets bit (lane offset of s + p) of the bank that owns s. The status register shows the bit after the clock edge that samples the pulse.
- R3: A clear pulse (`clr_vld`) clears the same bit position. If a set and a clear arrive in the same cycle, both are applied. When both name the same bit, the set wins.
- R4: `irq_out` is high one clock after (status0 & mask0) or (status1 & mask1) is nonzero, and low one clock after both are zero.
- R5: While `bus_rd` is high, any address 0x10..0x13 returns status bank 0 and any address 0x18..0x1B returns status bank 1. Bus writes to these addresses change nothing.
- R6: Mask 0 sits at address 0x20 and mask 1 at address 0x28. Both are read and written as full 32-bit values. A write takes effect at the clock edge that samples `bus_wr`.
- R7: After reset, all status and mask registers are zero and `irq_out` is low.
- R8: Set or clear pulses that carry slot number 7 change no status bit.
- R9: Reads of any other address return zero, and writes to them change no register. `bus_rdata` is zero while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Set request pulse |
| set_slot | input | 3 | Slot of the set request |
| set_port | input | 3 | Port of the set request |
| clr_vld | input | 1 | Clear request pulse |
| clr_slot | input | 3 | Slot of the clear request |
| clr_port | input | 3 | Port of the clear request |
| bus_addr | input | AW | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Combined network interrupt |

## Verification
Every slot and port pair from 0..7 by 0..7 is set alone. Both banks are then read back, which separates correct lane placement from a wrong bank or offset. The same sweep also shows that slot 7 writes nothing. Set and clear pulses are issued in the same cycle for different bits and for the same bit, to tell apart "both applied" from "one dropped" and to confirm that the set wins. Mask patterns that cover, miss, or cover only the other bank show whether the interrupt depends on both banks and on the masking. Writes to the status addresses and to unmapped addresses, followed by read-back, show that nothing was touched.

// File: rtl/netirq_agg.sv
module netirq_agg #(
  parameter int AW = 8,
  parameter logic [AW-1:0] ST0_ADDR = 'h10,
  parameter logic [AW-1:0] ST1_ADDR = 'h18,
  parameter logic [AW-1:0] MK0_ADDR = 'h20,
  parameter logic [AW-1:0] MK1_ADDR = 'h28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_vld,
  input  logic [2:0]    set_slot,
  input  logic [2:0]    set_port,
  input  logic          clr_vld,
  input  logic [2:0]    clr_slot,
  input  logic [2:0]    clr_port,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_out
);

  localparam int WIN = AW - 2;

  logic [31:0] st0, st1, mk0, mk1;
  logic [31:0] set0, set1, clr0, clr1;
  logic        hit_st0, hit_st1, hit_mk0, hit_mk1;

  function automatic logic [4:0] lane_off(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: lane_off = 5'd8;
      3'd4, 3'd6: lane_off = 5'd16;
      3'd3, 3'd5: lane_off = 5'd24;
      default:    lane_off = 5'd0;
    endcase
  endfunction

  function automatic logic in_bank1(input logic [2:0] s);
    in_bank1 = (s == 3'd2) || (s == 3'd5) || (s == 3'd6);
  endfunction

  function automatic logic [31:0] bit_of(input logic [2:0] s, input logic [2:0] p);
    bit_of = 32'h1 << (lane_off(s) + {2'b00, p});
  endfunction

  wire set_ok = set_vld && (set_slot != 3'd7);
  wire clr_ok = clr_vld && (clr_slot != 3'd7);

  assign set0 = (set_ok && !in_bank1(set_slot)) ? bit_of(set_slot, set_port) : 32'h0;
  assign set1 = (set_ok &&  in_bank1(set_slot)) ? bit_of(set_slot, set_port) : 32'h0;
  assign clr0 = (clr_ok && !in_bank1(clr_slot)) ? bit_of(clr_slot, clr_port) : 32'h0;
  assign clr1 = (clr_ok &&  in_bank1(clr_slot)) ? bit_of(clr_slot, clr_port) : 32'h0;

  assign hit_st0 = bus_addr[AW-1:2] == ST0_ADDR[AW-1:2];
  assign hit_st1 = bus_addr[AW-1:2] == ST1_ADDR[AW-1:2];
  assign hit_mk0 = bus_addr == MK0_ADDR;
  assign hit_mk1 = bus_addr == MK1_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st0 <= '0;
      st1 <= '0;
      mk0 <= '0;
      mk1 <= '0;
      irq_out <= 1'b0;
    end else begin
      st0 <= (st0 & ~clr0) | set0;
      st1 <= (st1 & ~clr1) | set1;
      if (bus_wr && hit_mk0) mk0 <= bus_wdata;
      if (bus_wr && hit_mk1) mk1 <= bus_wdata;
      irq_out <= |{st0 & mk0, st1 & mk1};
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd) begin
      if (hit_st0)      bus_rdata = st0;
      else if (hit_st1) bus_rdata = st1;
      else if (hit_mk0) bus_rdata = mk0;
      else if (hit_mk1) bus_rdata = mk1;
    end
  end

  logic unused_win;
  assign unused_win = WIN[0];

endmodule

// File: rtl/netirq_agg_chk.sv
module netirq_agg_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          set_vld,
  input logic [2:0]    set_slot,
  input logic [2:0]    set_port,
  input logic          clr_vld,
  input logic [2:0]    clr_slot,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          irq_out,
  input logic [31:0]   st0,
  input logic [31:0]   st1,
  input logic [31:0]   mk0,
  input logic [31:0]   mk1
);

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st0 & mk0) != 32'h0 || $past(st1 & mk1) != 32'h0) == irq_out);

  // R2
  set_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_slot == 3'd0) |=> st0[$past(set_port)]);

  // R5
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !set_vld && !clr_vld) |=> ($stable(st0) && $stable(st1)));

  // R6
  mask0_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h20)) |=> (mk0 == $past(bus_wdata)));

  // R8
  slot7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_slot == 3'd7 && (!clr_vld || clr_slot == 3'd7)) |=>
      ($stable(st0) && $stable(st1)));

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'h0));

  // R1
  bank1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st1[7:0] == 8'h0);

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(mk0) && $stable(mk1)));

endmodule

bind netirq_agg netirq_agg_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_slot(set_slot),
  .set_port(set_port), .clr_vld(clr_vld), .clr_slot(clr_slot),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .st0(st0), .st1(st1), .mk0(mk0), .mk1(mk1)
);

// File: tb/netirq_agg_test.sv
`timescale 1ns/1ps
module netirq_agg_test;
  logic clk = 0, rst_n = 0;
  logic set_vld = 0, clr_vld = 0, bus_rd = 0, bus_wr = 0;
  logic [2:0] set_slot = 0, set_port = 0, clr_slot = 0, clr_port = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_out;

  int vecs = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_st0 = 0, m_st1 = 0, m_mk0 = 0, m_mk1 = 0;

  always #2.5 clk = ~clk;

  netirq_agg uut (.*);

  function automatic int m_off(input int s);
    case (s)
      0: return 0;  1: return 8;  2: return 8;  3: return 24;
      4: return 16; 5: return 24; 6: return 16; default: return 0;
    endcase
  endfunction

  function automatic bit m_b1(input int s);
    return (s == 2) || (s == 5) || (s == 6);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic model_req(input bit sv, input int ss, input int sp,
                           input bit cv, input int cs, input int cp);
    logic [31:0] s0, s1, c0, c1;
    s0 = 0; s1 = 0; c0 = 0; c1 = 0;
    if (sv && ss < 7) begin
      if (m_b1(ss)) s1 = 32'h1 << (m_off(ss) + sp); else s0 = 32'h1 << (m_off(ss) + sp);
    end
    if (cv && cs < 7) begin
      if (m_b1(cs)) c1 = 32'h1 << (m_off(cs) + cp); else c0 = 32'h1 << (m_off(cs) + cp);
    end
    m_st0 = (m_st0 & ~c0) | s0;
    m_st1 = (m_st1 & ~c1) | s1;
  endtask

  task automatic req(input bit sv, input int ss, input int sp,
                     input bit cv, input int cs, input int cp);
    @(negedge clk);
    set_vld = sv; set_slot = 3'(ss); set_port = 3'(sp);
    clr_vld = cv; clr_slot = 3'(cs); clr_port = 3'(cp);
    @(negedge clk);
    set_vld = 0; clr_vld = 0;
    model_req(sv, ss, sp, cv, cs, cp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a == 8'h20) m_mk0 = d;
    if (a == 8'h28) m_mk1 = d;
  endtask

  task automatic rd(input string r, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 chk(r, bus_rdata, exp);
    bus_rd = 0;
  endtask

  function automatic logic m_irq();
    return ((m_st0 & m_mk0) != 0) || ((m_st1 & m_mk1) != 0);
  endfunction

  task automatic irq_chk(input string r);
    @(negedge clk);
    chk(r, {31'h0, irq_out}, {31'h0, m_irq()});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state
    chk("R7 irq", {31'h0, irq_out}, 32'h0);
    rd("R7 st0", 8'h10, 0); rd("R7 st1", 8'h18, 0);
    rd("R7 mk0", 8'h20, 0); rd("R7 mk1", 8'h28, 0);
    // R9 idle read data
    chk("R9 idle", bus_rdata, 0);

    // R1 R2 R3 R8 sweep, masks all ones for R4
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    rd("R6 mk0", 8'h20, 32'hFFFF_FFFF);
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 8; p++) begin
        req(1, s, p, 0, 0, 0);
        rd("R1/R2 st0", 8'h10 + 8'(p % 4), m_st0);
        rd("R1/R2 st1", 8'h18 + 8'((p + 1) % 4), m_st1);
        irq_chk("R4 sweep");
        req(0, 0, 0, 1, s, p);
        rd("R3 clr st0", 8'h10, m_st0);
        rd("R3 clr st1", 8'h18, m_st1);
        irq_chk("R4 sweep clr");
      end
    end
    // R8 slot 7 explicitly
    req(1, 7, 0, 0, 0, 0);
    rd("R8 st0", 8'h10, 0); rd("R8 st1", 8'h18, 0);

    // R3 simultaneous different bits
    req(1, 0, 3, 0, 0, 0);
    req(1, 1, 2, 1, 0, 3);
    rd("R3 both st0", 8'h10, 32'h0000_0400);
    // R3 same bit: set wins
    req(1, 5, 6, 1, 5, 6);
    rd("R3 same st1", 8'h18, 32'h4000_0000);
    // R3 clear of slot 7 ignored (R8)
    req(0, 0, 0, 1, 7, 2);
    rd("R8 clr7 st0", 8'h10, 32'h0000_0400);

    // R4 masking patterns
    wr(8'h20, 0); wr(8'h28, 0); irq_chk("R4 all masked");
    wr(8'h20, 32'h0000_0400); irq_chk("R4 bank0 hit");
    wr(8'h20, 32'hFFFF_FBFF); irq_chk("R4 bank0 miss");
    wr(8'h28, 32'h4000_0000); irq_chk("R4 bank1 hit");
    wr(8'h28, 0); irq_chk("R4 bank1 off");
    req(1, 4, 7, 0, 0, 0); irq_chk("R4 new bit under mask");
    chk("R4 value", {31'h0, irq_out}, 32'h1);
    req(0, 0, 0, 1, 4, 7); irq_chk("R4 cleared");

    // R5 writes to status ignored
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h1B, 32'hFFFF_FFFF);
    rd("R5 st0 ro", 8'h13, m_st0); rd("R5 st1 ro", 8'h19, m_st1);
    // R6 readback distinct patterns
    wr(8'h20, 32'hA5C3_0F1E); wr(8'h28, 32'h1234_8765);
    rd("R6 mk0", 8'h20, 32'hA5C3_0F1E); rd("R6 mk1", 8'h28, 32'h1234_8765);
    // R9 unmapped
    for (int a = 0; a < 64; a += 4) begin
      if (a == 8'h10 || a == 8'h18 || a == 8'h20 || a == 8'h28) continue;
      wr(8'(a), 32'hDEAD_BEEF);
      rd("R9 unmapped", 8'(a), 0);
    end
    rd("R9 near mask", 8'h21, 0);
    rd("R9 mk0 kept", 8'h20, 32'hA5C3_0F1E);
    rd("R9 mk1 kept", 8'h28, 32'h1234_8765);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule